// File: doc/BRIEF.md
# Five-source trigger combiner with delay and one-shot arming

This block builds one acquisition trigger from five asynchronous lines: four channel discriminators and one external input. Each line is first brought into the clock domain. A single polarity bit can then invert all of them together. A 16-bit selection word places each source in an OR group, a coincidence (AND) group, both or neither. The two group results are ORed into one combined level. A rising edge of that level, or a one-cycle software trigger, is a detection.

A detection is accepted only when three conditions hold: the block is enabled, it is armed, and no delay is in progress. An accepted detection does four things. It disarms the block, records the synchronized source levels on a snapshot bus, raises busy and loads a tick counter. When the counter runs out, the block emits a single-cycle trigger pulse and drops busy. No further detection is accepted until the readout side sends a re-arm strobe. Control and status pins are plain levels and strobes, so there is no back-pressure.

Source mapping, used throughout: `src_in[0]` to `src_in[3]` are channels 1 to 4, and `src_in[4]` is the external input.

Top module: `trig_combiner`

## Requirements
- R1: Selection bit i (i = 0..4) puts `src_in[i]` into the OR group. The OR group is high when any selected source is active.
- R2: Selection bit 8+i (i = 0..4) puts `src_in[i]` into the coincidence group. That group is high only while every selected source is active at the same time. Pulses that do not overlap give no trigger.
- R3: A group with no selected source contributes 0. An empty coincidence group never evaluates true.
- R4: Selection bits 5..7 and 13..15 have no effect on triggering.
- R5: Each source passes through two synchronizing flops, then through the shared polarity bit (1 means active-low for all five sources). A detection is a rising edge of the combined level. An input change sampled at clock edge A can be accepted at edge A+2.
- R6: A detection accepted at edge E with delay value D gives `trig_out` high for exactly one cycle, after edge E+D+1.
- R7: Reset leaves the block armed. Acceptance disarms it. Further detections are ignored until a one-cycle `rearm` strobe arms it again. If `rearm` and an acceptance fall on the same edge, the acceptance wins and the block ends up disarmed.
- R8: While `enable` is low, no detection is accepted and the armed state is left unchanged.
- R9: At acceptance, `src_snapshot` captures the five synchronized source levels before polarity inversion. It holds that value until the next acceptance.
- R10: `busy` is high from the acceptance edge until the edge that raises `trig_out`. Detections that arrive while busy is high are ignored.
- R11: `soft_trig` bypasses the group logic and the polarity. It still needs enable, armed and not busy.
- R12: After reset, `trig_out`, `busy` and `src_snapshot` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 5 | Raw trigger lines (channels 1-4, external) |
| sel_word | input | 16 | Group selection word |
| neg_pol | input | 1 | Invert all sources |
| delay_ticks | input | 8 | Delay in clock ticks |
| enable | input | 1 | Acceptance enable |
| rearm | input | 1 | One-cycle re-arm strobe |
| soft_trig | input | 1 | One-cycle software trigger |
| trig_out | output | 1 | Delayed single-cycle trigger |
| src_snapshot | output | 5 | Synchronized source levels at acceptance |
| busy | output | 1 | Delay in progress |

## Verification
The hardest case to reach is a polarity flip or a selection change that raises the combined level on its own. Without care, such a change would produce a stray detection. The stimulus therefore makes every configuration change with `enable` low and gives the sync stages time to settle, so that any such edge is dropped without disarming. Active-low operation is reached by raising the external line first and only then inverting. A second hard case is a re-arm strobe that arrives while a long delay is still running. It is produced by strobing mid-delay and then sending an edge before the pulse, which must be ignored, and another edge after the pulse, which must be taken.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned NUM_ANALOG = 4;
  localparam int unsigned NUM_SRC    = NUM_ANALOG + 1;
  localparam int unsigned SEL_W      = 16;
  localparam int unsigned OR_LSB     = 0;
  localparam int unsigned AND_LSB    = 8;
  localparam int unsigned DLY_W      = 8;

  typedef struct packed {
    logic [NUM_SRC-1:0] or_mask;
    logic [NUM_SRC-1:0] and_mask;
  } grp_sel_t;

  function automatic grp_sel_t decode_sel(input logic [SEL_W-1:0] w);
    grp_sel_t g;
    g.or_mask  = w[OR_LSB  +: NUM_SRC];
    g.and_mask = w[AND_LSB +: NUM_SRC];
    return g;
  endfunction
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/trig_groups.sv
module trig_groups
  import trig_pkg::*;
#(
  parameter int unsigned N   = NUM_SRC,
  parameter int unsigned SW  = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  lvl_sync,
  input  logic [SW-1:0] sel_word,
  input  logic          neg_pol,
  output logic          det_edge
);
  grp_sel_t      g;
  logic [N-1:0]  lvl_act;
  logic          or_hit;
  logic          and_hit;
  logic          comb_lvl;
  logic          comb_prev;

  assign g       = decode_sel(sel_word);
  assign lvl_act = lvl_sync ^ {N{neg_pol}};
  assign or_hit  = |(lvl_act & g.or_mask);
  assign and_hit = (g.and_mask != '0) && ((lvl_act & g.and_mask) == g.and_mask);
  assign comb_lvl = or_hit | and_hit;
  assign det_edge = comb_lvl & ~comb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) comb_prev <= 1'b0;
    else        comb_prev <= comb_lvl;
  end

  AST_EMPTY_SEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (g.or_mask == '0 && g.and_mask == '0) |-> !det_edge); // R3
  AST_EDGE_NEEDS_LOW_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
    det_edge |=> !det_edge); // R5
endmodule

// File: rtl/trig_delay.sv
module trig_delay
  import trig_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = DLY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_edge,
  input  logic          soft_trig,
  input  logic          enable,
  input  logic          rearm,
  input  logic [DW-1:0] delay_ticks,
  input  logic [N-1:0]  lvl_sync,
  output logic          trig_out,
  output logic          busy,
  output logic [N-1:0]  src_snapshot
);
  logic          armed;
  logic [DW-1:0] remain;
  logic          accept;
  logic          expire;

  assign accept = (det_edge | soft_trig) & enable & armed & ~busy;
  assign expire = busy & (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b1;
    else if (accept) armed <= 1'b0;
    else if (rearm)  armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      remain <= delay_ticks;
    end else if (expire) begin
      busy   <= 1'b0;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_out <= 1'b0;
    else        trig_out <= expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_snapshot <= '0;
    else if (accept) src_snapshot <= lvl_sync;
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out); // R6
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !armed); // R7
  AST_PULSE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (!busy && $past(busy))); // R10
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(src_snapshot)); // R9
  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable)); // R8
endmodule

// File: rtl/trig_combiner.sv
module trig_combiner
  import trig_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned SW = SEL_W,
  parameter int unsigned DW = DLY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_in,
  input  logic [SW-1:0] sel_word,
  input  logic          neg_pol,
  input  logic [DW-1:0] delay_ticks,
  input  logic          enable,
  input  logic          rearm,
  input  logic          soft_trig,
  output logic          trig_out,
  output logic [N-1:0]  src_snapshot,
  output logic          busy
);
  logic [N-1:0] lvl_sync;
  logic         det_edge;

  trig_sync #(.WIDTH(N), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (src_in),
    .q_sync  (lvl_sync)
  );

  trig_groups #(.N(N), .SW(SW)) u_groups (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_sync (lvl_sync),
    .sel_word (sel_word),
    .neg_pol  (neg_pol),
    .det_edge (det_edge)
  );

  trig_delay #(.N(N), .DW(DW)) u_delay (
    .clk          (clk),
    .rst_n        (rst_n),
    .det_edge     (det_edge),
    .soft_trig    (soft_trig),
    .enable       (enable),
    .rearm        (rearm),
    .delay_ticks  (delay_ticks),
    .lvl_sync     (lvl_sync),
    .trig_out     (trig_out),
    .busy         (busy),
    .src_snapshot (src_snapshot)
  );

  AST_BUSY_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> !trig_out); // R10
endmodule

// File: tb/trig_combiner_test.sv
module trig_combiner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_in = '0;
  logic [15:0] sel_word = '0;
  logic        neg_pol = 1'b0;
  logic [7:0]  delay_ticks = '0;
  logic        enable = 1'b0;
  logic        rearm = 1'b0;
  logic        soft_trig = 1'b0;
  logic        trig_out;
  logic [4:0]  src_snapshot;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  trig_combiner uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .sel_word(sel_word),
    .neg_pol(neg_pol), .delay_ticks(delay_ticks), .enable(enable),
    .rearm(rearm), .soft_trig(soft_trig), .trig_out(trig_out),
    .src_snapshot(src_snapshot), .busy(busy)
  );

  // behavioural reference model
  bit [4:0] m_q1 = '0, m_q2 = '0, m_snap = '0;
  bit       m_prev = 0, m_armed = 1, m_busy = 0, m_out = 0;
  int       m_left = 0;

  function automatic bit model_level(bit [4:0] lv, bit [15:0] w, bit inv);
    bit any_or = 0;
    int n_and = 0;
    bit all_and = 1;
    for (int i = 0; i < 5; i++) begin
      bit a = lv[i] ^ inv;
      if (w[i] && a) any_or = 1;
      if (w[8+i]) begin
        n_and++;
        if (!a) all_and = 0;
      end
    end
    return any_or || (n_and > 0 && all_and);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q1 = '0; m_q2 = '0; m_snap = '0; m_prev = 0;
      m_armed = 1; m_busy = 0; m_out = 0; m_left = 0;
    end else begin
      bit lvl, acc;
      lvl = model_level(m_q2, sel_word, neg_pol);
      acc = ((lvl && !m_prev) || soft_trig) && enable && m_armed && !m_busy;
      m_out = 0;
      if (acc) begin
        m_busy = 1; m_left = delay_ticks; m_armed = 0; m_snap = m_q2;
      end else begin
        if (rearm) m_armed = 1;
        if (m_busy) begin
          if (m_left == 0) begin m_out = 1; m_busy = 0; end
          else m_left--;
        end
      end
      m_prev = lvl;
      m_q2 = m_q1;
      m_q1 = src_in;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (trig_out) pulses++;
    checks += 3;
    if (trig_out !== m_out) begin
      fails++; $display("FAIL R6 trig_out actual=%0b expected=%0b t=%0t", trig_out, m_out, $time);
    end
    if (busy !== m_busy) begin
      fails++; $display("FAIL R10 busy actual=%0b expected=%0b t=%0t", busy, m_busy, $time);
    end
    if (src_snapshot !== m_snap) begin
      fails++; $display("FAIL R9 snapshot actual=%b expected=%b t=%0t", src_snapshot, m_snap, $time);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(logic [15:0] w, logic inv, logic [7:0] d);
    enable = 0;
    sel_word = w; neg_pol = inv; delay_ticks = d;
    tick(6);
    enable = 1;
    tick(1);
  endtask

  task automatic do_rearm();
    rearm = 1; tick(1); rearm = 0;
  endtask

  task automatic expect_pulses(int base, int exp, string tag);
    checks++;
    if (pulses - base != exp) begin
      fails++;
      $display("FAIL %s pulses actual=%0d expected=%0d", tag, pulses - base, exp);
    end
  endtask

  task automatic blip(logic [4:0] v, int hold, int rest);
    src_in = v; tick(hold); src_in = '0; tick(rest);
  endtask

  initial begin
    int base;
    int k;
    tick(3);
    // R12 reset state
    checks++;
    if (trig_out !== 0 || busy !== 0 || src_snapshot !== 0) begin
      fails++; $display("FAIL R12 reset outs actual=%b%b%b expected=0", trig_out, busy, src_snapshot);
    end
    rst_n = 1;
    tick(2);

    // R1 OR group on channel 3
    configure(16'h0004, 0, 8'd3); do_rearm();
    base = pulses; blip(5'b00100, 3, 12);
    expect_pulses(base, 1, "R1");
    do_rearm(); base = pulses; blip(5'b00010, 3, 12);
    expect_pulses(base, 0, "R1 unselected");

    // R2 coincidence of channels 1 and 2
    configure(16'h0300, 0, 8'd2); do_rearm();
    base = pulses; blip(5'b00001, 3, 4); blip(5'b00010, 3, 10);
    expect_pulses(base, 0, "R2 no overlap");
    base = pulses; src_in = 5'b00001; tick(2); src_in = 5'b00011; tick(3); src_in = '0; tick(10);
    expect_pulses(base, 1, "R2 overlap");

    // R3 empty groups
    configure(16'h0000, 0, 8'd1); do_rearm();
    base = pulses; blip(5'b11111, 4, 10);
    expect_pulses(base, 0, "R3 all empty");
    configure(16'h0010, 0, 8'd1); do_rearm();
    base = pulses; blip(5'b11111, 4, 10);
    expect_pulses(base, 1, "R3 empty AND no effect");

    // R4 reserved bits
    configure(16'hE0E0, 0, 8'd1); do_rearm();
    base = pulses; blip(5'b11111, 4, 10);
    expect_pulses(base, 0, "R4");

    // R5 active-low external input
    configure(16'h0010, 0, 8'd2);
    enable = 0; src_in = 5'b10000; tick(5); neg_pol = 1; tick(5); enable = 1; tick(1);
    do_rearm();
    base = pulses; src_in = '0; tick(12); src_in = 5'b10000; tick(12);
    expect_pulses(base, 1, "R5 inverted");
    enable = 0; neg_pol = 0; src_in = '0; tick(6);

    // R6 latency with delay 0 and 20
    configure(16'h0001, 0, 8'd0); do_rearm();
    src_in = 5'b00001; k = 0;
    do begin tick(1); k++; end while (!trig_out && k < 100);
    checks++;
    if (k != 4) begin fails++; $display("FAIL R6 latency d=0 actual=%0d expected=4", k); end
    src_in = '0; tick(4);
    configure(16'h0001, 0, 8'd20); do_rearm();
    src_in = 5'b00001; k = 0;
    do begin tick(1); k++; end while (!trig_out && k < 100);
    checks++;
    if (k != 24) begin fails++; $display("FAIL R6 latency d=20 actual=%0d expected=24", k); end
    src_in = '0; tick(4);

    // R7 one-shot until re-armed
    configure(16'h0001, 0, 8'd1);
    base = pulses; blip(5'b00001, 3, 10);
    expect_pulses(base, 0, "R7 disarmed");
    do_rearm(); base = pulses; blip(5'b00001, 3, 10);
    expect_pulses(base, 1, "R7 rearmed");

    // R8 enable gating keeps arm
    do_rearm(); enable = 0;
    base = pulses; blip(5'b00001, 3, 10);
    expect_pulses(base, 0, "R8 disabled");
    enable = 1; tick(1);
    base = pulses; blip(5'b00001, 3, 10);
    expect_pulses(base, 1, "R8 still armed");

    // R9 snapshot of raw levels
    configure(16'h0001, 0, 8'd1); do_rearm();
    src_in = 5'b00101; tick(10);
    checks++;
    if (src_snapshot !== 5'b00101) begin
      fails++; $display("FAIL R9 snapshot actual=%b expected=00101", src_snapshot);
    end
    src_in = '0; tick(4);

    // R10 edges during busy are ignored, rearm mid-delay
    configure(16'h0001, 0, 8'd30); do_rearm();
    base = pulses; blip(5'b00001, 2, 3); do_rearm(); blip(5'b00001, 2, 40);
    expect_pulses(base, 1, "R10 busy ignore");
    base = pulses; blip(5'b00001, 2, 40);
    expect_pulses(base, 1, "R10 rearm during busy");

    // R11 software trigger
    configure(16'h0000, 0, 8'd1); do_rearm();
    base = pulses; soft_trig = 1; tick(1); soft_trig = 0; tick(8);
    expect_pulses(base, 1, "R11 soft");
    base = pulses; soft_trig = 1; tick(1); soft_trig = 0; tick(8);
    expect_pulses(base, 0, "R11 soft disarmed");

    tick(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule